// File: doc/BRIEF.md
# 32-bit Virtual Segment Decoder

This block sorts every 32-bit virtual address into one of five fixed regions and decides, within the same cycle, how the access proceeds. A lower-half address goes to the translation buffer. Two kernel windows in the upper half translate directly by removing a fixed base. The top two windows again go to the translation buffer. A user-mode access anywhere in the upper half is refused as an address error.

When the error-level flag is set, the lower half becomes an identity window. The address passes through unchanged with read and write granted, whatever the privilege mode. Direct translations also raise a permission flag that allows both read and write. The second direct window also raises an uncached flag, so that a downstream cache can let the access pass around it.

The block is purely combinational. Instantiate it between the address generator and the translation buffer, and feed its three outcome flags to the fault and cache logic.

Top module: `vseg_decoder`

## Requirements
- R1: When `user_mode` is 1 and `vaddr` is 0x80000000 or above, the outputs are `addr_err`=1, `need_tlb`=0, `direct_rw`=0, `uncached`=0 and `phys_addr`=0.
- R2: When `vaddr` is 0x7FFFFFFF or below and `erl`=0, the outputs are `need_tlb`=1, `addr_err`=0, `direct_rw`=0, `uncached`=0 and `phys_addr`=0, in either mode.
- R3: When `vaddr` is 0x7FFFFFFF or below and `erl`=1, the outputs are `phys_addr`=`vaddr`, `direct_rw`=1, `need_tlb`=0, `addr_err`=0 and `uncached`=0, in either mode.
- R4: In kernel mode, an address from 0x80000000 to 0x9FFFFFFF gives `phys_addr` = `vaddr` - 0x80000000, `direct_rw`=1 and `uncached`=0.
- R5: In kernel mode, an address from 0xA0000000 to 0xBFFFFFFF gives `phys_addr` = `vaddr` - 0xA0000000, `direct_rw`=1 and `uncached`=1. `uncached` is 1 for no other case.
- R6: In kernel mode, an address from 0xC0000000 to 0xDFFFFFFF gives `need_tlb`=1 and `phys_addr`=0.
- R7: In kernel mode, an address from 0xE0000000 to 0xFFFFFFFF gives `need_tlb`=1 and `phys_addr`=0. No special window exists at the top.
- R8: Exactly one of `need_tlb`, `direct_rw` and `addr_err` is 1 for every input.
- R9: `erl` has no effect on any output when `vaddr` is 0x80000000 or above.
- R10: All outputs follow the inputs combinationally, with no clock and no state. With all inputs at 0 the outputs are `need_tlb`=1 and `phys_addr`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vaddr | input | 32 | Virtual address of the access |
| user_mode | input | 1 | 1 when the access is made in user mode |
| erl | input | 1 | Error-level flag; makes the lower half an identity window |
| need_tlb | output | 1 | Address must be translated by the translation buffer |
| phys_addr | output | 32 | Physical address for direct translations, else 0 |
| direct_rw | output | 1 | Direct translation with read and write granted |
| uncached | output | 1 | Access falls in the uncached direct window |
| addr_err | output | 1 | Address error for the current mode |

## Verification
The block holds no state, so a wrong region choice or a wrong window base shows on the ports at once, for the same input vector. It appears as a wrong outcome flag, as a physical address off by a power-of-two base, or as an `uncached` flag on the wrong window. Each region boundary is driven from both sides. `erl` and `user_mode` are toggled against fixed addresses. This exposes a mode or flag that leaks into regions where it should have no effect. The one-of-three outcome rule is checked on every vector.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
   // Region codes produced by the decoder.
   typedef enum logic [2:0] {
      RG_LOW   = 3'd0,
      RG_DIR0  = 3'd1,
      RG_DIR1  = 3'd2,
      RG_MAP2  = 3'd3,
      RG_MAP3  = 3'd4
   } region_t;

   // Top-address-bit codes of the upper-half windows.
   localparam logic [2:0] SEL_DIR0 = 3'b100;
   localparam logic [2:0] SEL_DIR1 = 3'b101;
   localparam logic [2:0] SEL_MAP2 = 3'b110;
endpackage

// File: rtl/vseg_region_decode.sv
module vseg_region_decode
   import vseg_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0] top_bits,
   output region_t          region
);
   generate
      if (SEL_W != 3) begin : g_bad_sel
         $error("vseg_region_decode: SEL_W must be 3");
      end
   endgenerate

   always_comb begin
      if (!top_bits[SEL_W-1])            region = RG_LOW;
      else if (top_bits == SEL_DIR0)     region = RG_DIR0;
      else if (top_bits == SEL_DIR1)     region = RG_DIR1;
      else if (top_bits == SEL_MAP2)     region = RG_MAP2;
      else                               region = RG_MAP3;
   end
endmodule

// File: rtl/vseg_direct_map.sv
module vseg_direct_map
   import vseg_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SEL_W      = 3,
   parameter bit SUBTRACTOR = 1'b0
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  region_t           region,
   output logic [ADDR_W-1:0] dir_addr
);
   localparam int OFF_W = ADDR_W - SEL_W;

   generate
      if (ADDR_W < SEL_W + 4) begin : g_bad_width
         $error("vseg_direct_map: ADDR_W too small");
      end
      if (SUBTRACTOR) begin : g_sub
         logic [ADDR_W-1:0] base;
         always_comb begin
            base = '0;
            if (region == RG_DIR0) base = {SEL_DIR0, {OFF_W{1'b0}}};
            if (region == RG_DIR1) base = {SEL_DIR1, {OFF_W{1'b0}}};
            dir_addr = vaddr - base;
         end
      end else begin : g_mask
         always_comb begin
            dir_addr = {{SEL_W{1'b0}}, vaddr[OFF_W-1:0]};
         end
      end
   endgenerate
endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
   import vseg_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SEL_W      = 3,
   parameter bit SUBTRACTOR = 1'b0
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              user_mode,
   input  logic              erl,
   output logic              need_tlb,
   output logic [ADDR_W-1:0] phys_addr,
   output logic              direct_rw,
   output logic              uncached,
   output logic              addr_err
);
   localparam int OFF_W = ADDR_W - SEL_W;

   generate
      if (OFF_W < 4) begin : g_bad_off
         $error("vseg_decoder: offset field too narrow");
      end
   endgenerate

   region_t           region;
   logic [ADDR_W-1:0] dir_addr;

   vseg_region_decode #(.SEL_W(SEL_W)) u_region (
      .top_bits (vaddr[ADDR_W-1:OFF_W]),
      .region   (region)
   );

   vseg_direct_map #(
      .ADDR_W     (ADDR_W),
      .SEL_W      (SEL_W),
      .SUBTRACTOR (SUBTRACTOR)
   ) u_direct (
      .vaddr    (vaddr),
      .region   (region),
      .dir_addr (dir_addr)
   );

   always_comb begin
      need_tlb  = 1'b0;
      direct_rw = 1'b0;
      uncached  = 1'b0;
      addr_err  = 1'b0;
      phys_addr = '0;
      if (user_mode && region != RG_LOW) begin
         addr_err = 1'b1;
      end else begin
         unique case (region)
            RG_LOW: begin
               if (erl) begin
                  direct_rw = 1'b1;
                  phys_addr = vaddr;
               end else begin
                  need_tlb = 1'b1;
               end
            end
            RG_DIR0: begin
               direct_rw = 1'b1;
               phys_addr = dir_addr;
            end
            RG_DIR1: begin
               direct_rw = 1'b1;
               uncached  = 1'b1;
               phys_addr = dir_addr;
            end
            default: need_tlb = 1'b1;
         endcase
      end
   end

   // Checks next to the outcome logic.
   always_comb begin
      AST_ONE_OUTCOME: assert ($countones({need_tlb, direct_rw, addr_err}) == 1)
         else $error("outcome flags not one-of-three"); // R8
      AST_USER_UPPER: assert (!(user_mode && vaddr[ADDR_W-1]) || addr_err)
         else $error("user access to upper half not refused"); // R1
      AST_UNCACHED_WIN: assert (!uncached || (vaddr[ADDR_W-1:OFF_W] == SEL_DIR1 && direct_rw))
         else $error("uncached outside its window"); // R5
      AST_ERL_IDENT: assert (!(erl && !vaddr[ADDR_W-1]) || phys_addr == vaddr)
         else $error("identity window broken"); // R3
      AST_DIRECT_RANGE: assert (!(direct_rw && vaddr[ADDR_W-1]) || phys_addr[ADDR_W-1:OFF_W] == '0)
         else $error("direct window result out of range"); // R4
      AST_NO_PHYS_ON_TLB: assert (!need_tlb || phys_addr == '0)
         else $error("physical address driven on a mapped access"); // R6
   end
endmodule

// File: tb/sim_vseg_decoder.sv
module sim_vseg_decoder;
   typedef struct {
      logic [31:0] va;
      logic        um;
      logic        el;
      logic        tlb;
      logic [31:0] pa;
      logic        drw;
      logic        unc;
      logic        err;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] vaddr = '0;
   logic        user_mode = 1'b0;
   logic        erl = 1'b0;
   logic        need_tlb, direct_rw, uncached, addr_err;
   logic [31:0] phys_addr;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;
   item_t q[$];

   always #2 clk = ~clk;

   vseg_decoder u0 (
      .vaddr     (vaddr),
      .user_mode (user_mode),
      .erl       (erl),
      .need_tlb  (need_tlb),
      .phys_addr (phys_addr),
      .direct_rw (direct_rw),
      .uncached  (uncached),
      .addr_err  (addr_err)
   );

   // Expected outcome built from the requirement text.
   function automatic item_t model(input logic [31:0] va, input logic um,
                                   input logic el, input string tag);
      item_t it;
      it.va = va; it.um = um; it.el = el; it.tag = tag;
      it.tlb = 0; it.pa = 0; it.drw = 0; it.unc = 0; it.err = 0;
      if (va <= 32'h7FFF_FFFF) begin
         if (el) begin it.drw = 1; it.pa = va; end
         else it.tlb = 1;
      end else if (um) begin
         it.err = 1;
      end else if (va < 32'hA000_0000) begin
         it.drw = 1; it.pa = va - 32'h8000_0000;
      end else if (va < 32'hC000_0000) begin
         it.drw = 1; it.unc = 1; it.pa = va - 32'hA000_0000;
      end else begin
         it.tlb = 1;
      end
      return it;
   endfunction

   task automatic drive(input logic [31:0] va, input logic um, input logic el,
                        input string tag);
      @(posedge clk);
      vaddr = va; user_mode = um; erl = el;
      q.push_back(model(va, um, el, tag));
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                        input string what);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Monitor: compares half a cycle after each drive.
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(it.tag, phys_addr, it.pa, "phys_addr");
            check(it.tag, {28'd0, need_tlb, direct_rw, uncached, addr_err},
                  {28'd0, it.tlb, it.drw, it.unc, it.err}, "flags tlb/drw/unc/err");
            check("R8", {31'd0, ($countones({need_tlb, direct_rw, addr_err}) == 1)},
                  32'd1, "one outcome");
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      drive(32'h0000_0000, 0, 0, "R10 reset-state");
      drive(32'h0000_1000, 0, 0, "R2");
      drive(32'h7FFF_FFFF, 1, 0, "R2");
      drive(32'h1234_5678, 1, 0, "R2");
      drive(32'h7FFF_FFFF, 0, 1, "R3");
      drive(32'h2345_6789, 1, 1, "R3");
      drive(32'h8000_0000, 1, 0, "R1");
      drive(32'hA000_0000, 1, 0, "R1");
      drive(32'hFFFF_FFFF, 1, 0, "R1");
      drive(32'hF000_0000, 1, 1, "R1 R9");
      drive(32'h8000_0000, 0, 0, "R4");
      drive(32'h9FFF_FFFF, 0, 0, "R4");
      drive(32'h8765_4321, 0, 0, "R4");
      drive(32'hA000_0000, 0, 0, "R5");
      drive(32'hBFFF_FFFF, 0, 0, "R5");
      drive(32'hB123_4567, 0, 0, "R5");
      drive(32'hC000_0000, 0, 0, "R6");
      drive(32'hDFFF_FFFF, 0, 0, "R6");
      drive(32'hE000_0000, 0, 0, "R7");
      drive(32'hFFFF_FFFF, 0, 0, "R7");
      drive(32'h9000_0010, 0, 1, "R9");
      drive(32'hB000_0010, 0, 1, "R9");
      drive(32'hC000_0010, 0, 1, "R9");
      drive(32'hE800_0000, 0, 1, "R9");
      for (int i = 0; i < 16; i++) begin
         drive({i[3:0], 28'h5A5_A5A5}, i[0], i[1], "R10 sweep");
      end
      @(posedge clk);
      wait (q.size() == 0);
      @(posedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end
endmodule